// File: doc/BRIEF.md
# Multi-mode ADC conversion sequencer

This block is the digital half of an eight-input successive-approximation A/D converter. Software programs it through a small byte-wide register bus: a control byte for mode and channel window, a control/status byte for triggers, interrupt and busy state, and a two-byte result holder. Once triggered, it selects an analog channel, holds a sample phase, then runs a bit-by-bit binary search. On each step it drives a trial code to an external DAC and reads back a single comparator bit. At the end of every conversion it latches the result and raises an interrupt flag.

Four sequencing behaviours are provided. A one-shot pass covers a channel window (one channel when the first and last are equal). A repeating pass loops over the window until aborted. A stepped pass converts one channel per trigger and then waits. A conversion may be launched by a register write, by a falling edge on an external pin, or by a rising edge from a timer, and each hardware source is enabled separately. Results are either 10 bits or 8 bits wide. A result that completes while the previous one is still unacknowledged parks the sequencer until software acknowledges.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset all four register bytes read 0x00, `irq` is 0, `sample_en` is 0, and the block stays idle until a trigger is accepted.
- R2: A conversion takes exactly 98 clock cycles from the clock edge that accepts the trigger. `sample_en` is high for the first 60 of them. The interrupt flag (control/status bit 6) reads 1 after edge 98 and 0 after edge 97. The busy flag (bit 7) reads 1 throughout.
- R3: With the resolution bit (result high byte bit 7) at 1, the result equals the largest 10-bit code not above the comparator threshold, read as bits 7..0 in the low byte (address 2) and bits 9..8 in bits 1..0 of the high byte (address 3). Bits 6..2 of the high byte read 0.
- R4: With the resolution bit at 0, only 8 trial steps run. The low byte holds the upper 8 bits of the 10-bit value and bits 1..0 of the high byte read 0.
- R5: The control byte (address 0) holds mode in bits 7..6, first channel in 5..3 and last channel in 2..0. Mode 00 or 01 converts first..last once, back to back, then clears busy.
- R6: When the last channel is below the first, the walk goes upward and wraps from channel 7 to channel 0.
- R7: Mode 10 loops over the window without end. Writing the control/status byte (address 1) with bit 7 = 0 while busy in mode 10 or 11 stops at once: busy clears and sampling stops.
- R8: Mode 11 converts one channel per trigger, keeping busy at 1 between triggers. Each new trigger converts the next channel of the window, and after the last channel it returns to the first.
- R9: Control/status bits 3..2 enable hardware triggers: bit 2 the external pin falling edge, bit 3 the timer rising edge. A write with bit 1 set always triggers. A disabled source has no effect.
- R10: A trigger that arrives while a conversion or a pass is in progress is ignored and does not disturb the channel order.
- R11: `irq` equals the interrupt flag ANDed with the enable (bit 5). Writing bit 6 as 0 clears the flag, and writing it as 1 leaves it unchanged.
- R12: If a conversion completes while the interrupt flag is still set, the pause flag (bit 4) goes to 1 and sampling stops. Clearing the interrupt flag clears the pause and continues the pass with its next conversion, which ends 98 cycles after that write.
- R13: The start bit (bit 1) and bit 0 of the control/status byte always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Machine clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register byte select: 0 control, 1 control/status, 2 result low, 3 result high |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the byte at `bus_addr`, combinational |
| ext_trig_n | input | 1 | External trigger pin, acts on a falling edge |
| tmr_trig | input | 1 | Timer trigger, acts on a rising edge |
| cmp_hi | input | 1 | Comparator: 1 when the analog input is at or above `trial_code` |
| trial_code | output | 10 | Code presented to the DAC during approximation |
| sample_en | output | 1 | Sample-and-hold gate |
| chan_sel | output | 3 | Analog multiplexer channel |
| irq | output | 1 | Interrupt request |

## Verification
The embedded properties assume that the comparator answers within the same cycle as the trial code. They also assume that the resolution bit is not rewritten while a conversion is running, since the trial-step count is fixed when sampling starts. The bench models each analog channel as a fixed integer and compares it against `trial_code` combinationally. It changes the resolution bit and the channel window only while the block is idle. In repeating and stepped modes it acknowledges the interrupt with bit 7 held at 1, so an acknowledgement never counts as an abort.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int RES_W = 10;
  localparam int LO_W  = 8;
  localparam int CH_W  = 3;
  localparam int REG_W = 8;

  localparam logic [1:0] A_CTL    = 2'd0;
  localparam logic [1:0] A_STAT   = 2'd1;
  localparam logic [1:0] A_RES_LO = 2'd2;
  localparam logic [1:0] A_RES_HI = 2'd3;

  typedef enum logic [1:0] {MD_ONCE_A = 2'b00, MD_ONCE_B = 2'b01,
                            MD_LOOP = 2'b10, MD_STEP = 2'b11} seq_mode_e;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_WAIT, ST_PAUSE} seq_st_e;
  typedef enum logic [1:0] {PH_IDLE, PH_SMP, PH_CNV} core_ph_e;
  typedef enum logic [1:0] {NX_IDLE, NX_RUN, NX_WAIT} nx_kind_e;

  typedef struct packed {
    nx_kind_e          kind;
    logic [CH_W-1:0]   chan;
  } nx_t;

  // Trial code: accepted bits so far plus the bit under test.
  function automatic logic [RES_W-1:0] sar_trial(input logic [RES_W-1:0] acc,
                                                 input int unsigned step);
    sar_trial = acc | (RES_W'(1) << (RES_W - 1 - step));
  endfunction

  // Register view of the accumulator for the chosen resolution.
  function automatic logic [RES_W-1:0] fmt_result(input logic [RES_W-1:0] acc,
                                                  input logic full);
    fmt_result = full ? acc : (acc >> (RES_W - LO_W));
  endfunction

  // Decision taken after a finished conversion.
  function automatic nx_t next_step(input seq_mode_e md, input logic [CH_W-1:0] cur,
                                    input logic [CH_W-1:0] first,
                                    input logic [CH_W-1:0] last);
    nx_t r;
    logic [CH_W-1:0] up;
    up = cur + 1'b1;
    r.chan = (cur == last) ? first : up;
    case (md)
      MD_LOOP: r.kind = NX_RUN;
      MD_STEP: r.kind = NX_WAIT;
      default: r.kind = (cur == last) ? NX_IDLE : NX_RUN;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/adc_edge_det.sv
module adc_edge_det #(
  parameter bit RISING = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic pulse
);
  logic q;

  always_ff @(posedge clk) begin
    if (!rst_n) q <= !RISING;
    else        q <= din;
  end

  generate
    if (RISING) begin : g_rise
      assign pulse = din & ~q;
    end else begin : g_fall
      assign pulse = ~din & q;
    end
  endgenerate
endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core import adc_seq_pkg::*; #(
  parameter int SAMPLE_CYC = 60,
  parameter int CONV_CYC   = 98
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic             res_full,
  input  logic             cmp_hi,
  output logic             sampling,
  output logic             busy,
  output logic             done,
  output logic [RES_W-1:0] acc,
  output logic [RES_W-1:0] trial
);
  localparam int CONV_LEN = CONV_CYC - SAMPLE_CYC;
  localparam int CW       = $clog2(CONV_CYC + 1);

  core_ph_e        ph;
  logic [CW-1:0]   cnt;
  logic            full_q;
  logic            seen_q;
  logic [CW-1:0]   nbits;
  logic            step_act;

  assign nbits    = full_q ? CW'(RES_W) : CW'(LO_W);
  assign step_act = (ph == PH_CNV) && (cnt < nbits);
  assign trial    = step_act ? sar_trial(acc, int'(cnt)) : acc;
  assign sampling = (ph == PH_SMP);
  assign busy     = (ph != PH_IDLE);
  assign done     = (ph == PH_CNV) && (cnt == CW'(CONV_LEN - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph <= PH_IDLE; cnt <= '0; full_q <= 1'b0; seen_q <= 1'b0; acc <= '0;
    end else if (abort) begin
      ph <= PH_IDLE;
    end else if (start) begin
      ph <= PH_SMP; cnt <= '0; full_q <= res_full; seen_q <= 1'b0; acc <= '0;
    end else begin
      case (ph)
        PH_SMP: begin
          if (cnt == CW'(SAMPLE_CYC - 1)) begin
            ph <= PH_CNV; cnt <= '0; seen_q <= 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        PH_CNV: begin
          if (step_act && cmp_hi) acc <= trial;
          if (done) ph <= PH_IDLE;
          else      cnt <= cnt + 1'b1;
        end
        default: ;
      endcase
    end
  end

  // R2
  smp_before_cnv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> seen_q);

  // R4
  lo_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !full_q) |-> (acc[RES_W-LO_W-1:0] == '0));
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl import adc_seq_pkg::*; #(
  parameter int SAMPLE_CYC = 60,
  parameter int CONV_CYC   = 98
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       bus_addr,
  input  logic             bus_wr,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  input  logic             ext_trig_n,
  input  logic             tmr_trig,
  input  logic             cmp_hi,
  output logic [RES_W-1:0] trial_code,
  output logic             sample_en,
  output logic [CH_W-1:0]  chan_sel,
  output logic             irq
);
  seq_st_e         st_q;
  seq_mode_e       mode_q;
  logic [CH_W-1:0] first_q, last_q, chan_q;
  logic            busy_q, int_q, inte_q, paus_q, s10_q;
  logic [1:0]      src_q;
  logic [RES_W-1:0] result_q;

  logic ext_fall, tmr_rise;
  logic core_busy, core_done, core_start;
  logic [RES_W-1:0] core_acc;

  adc_edge_det #(.RISING(1'b0)) u_ext (.clk(clk), .rst_n(rst_n), .din(ext_trig_n), .pulse(ext_fall));
  adc_edge_det #(.RISING(1'b1)) u_tmr (.clk(clk), .rst_n(rst_n), .din(tmr_trig),   .pulse(tmr_rise));

  // Named internal events
  logic wr_ctl, wr_stat, wr_res_hi, sw_trig, trig_any, abort_ev, int_clr;
  logic accept, stall, release_ev, advance;
  nx_t  nx;

  assign wr_ctl     = bus_wr && (bus_addr == A_CTL);
  assign wr_stat    = bus_wr && (bus_addr == A_STAT);
  assign wr_res_hi  = bus_wr && (bus_addr == A_RES_HI);
  assign sw_trig    = wr_stat && bus_wdata[1];
  assign trig_any   = sw_trig | (src_q[0] & ext_fall) | (src_q[1] & tmr_rise);
  assign abort_ev   = wr_stat && busy_q && mode_q[1] && !bus_wdata[7];
  assign int_clr    = wr_stat && !bus_wdata[6];
  assign accept     = !abort_ev && trig_any && (st_q == ST_IDLE || st_q == ST_WAIT);
  assign stall      = core_done && int_q && !int_clr;
  assign release_ev = (st_q == ST_PAUSE) && int_clr;
  assign advance    = !abort_ev && ((core_done && !stall) || release_ev);
  assign nx         = next_step(mode_q, chan_q, first_q, last_q);
  assign core_start = accept || (advance && nx.kind == NX_RUN);

  adc_sar_core #(.SAMPLE_CYC(SAMPLE_CYC), .CONV_CYC(CONV_CYC)) u_core (
    .clk(clk), .rst_n(rst_n), .start(core_start), .abort(abort_ev),
    .res_full(s10_q), .cmp_hi(cmp_hi), .sampling(sample_en), .busy(core_busy),
    .done(core_done), .acc(core_acc), .trial(trial_code));

  assign chan_sel = (accept && st_q == ST_IDLE) ? first_q : chan_q;
  assign irq      = int_q & inte_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; mode_q <= MD_ONCE_A; first_q <= '0; last_q <= '0; chan_q <= '0;
      busy_q <= 1'b0; int_q <= 1'b0; inte_q <= 1'b0; paus_q <= 1'b0; s10_q <= 1'b0;
      src_q <= '0; result_q <= '0;
    end else begin
      if (wr_ctl) begin
        mode_q  <= seq_mode_e'(bus_wdata[7:6]);
        first_q <= bus_wdata[5:3];
        last_q  <= bus_wdata[2:0];
      end
      if (wr_res_hi) s10_q <= bus_wdata[7];
      if (wr_stat) begin
        inte_q <= bus_wdata[5];
        src_q  <= bus_wdata[3:2];
      end
      if (core_done) result_q <= fmt_result(core_acc, s10_q);
      if (core_done)    int_q <= 1'b1;
      else if (int_clr) int_q <= 1'b0;

      if (abort_ev) begin
        busy_q <= 1'b0; st_q <= ST_IDLE; paus_q <= 1'b0;
      end else begin
        if (stall)        paus_q <= 1'b1;
        else if (int_clr) paus_q <= 1'b0;
        if (accept) begin
          busy_q <= 1'b1; st_q <= ST_RUN;
          if (st_q == ST_IDLE) chan_q <= first_q;
        end else if (stall) begin
          st_q <= ST_PAUSE;
        end else if (advance) begin
          case (nx.kind)
            NX_IDLE: begin busy_q <= 1'b0; st_q <= ST_IDLE; end
            NX_WAIT: begin st_q <= ST_WAIT; chan_q <= nx.chan; end
            default: begin st_q <= ST_RUN;  chan_q <= nx.chan; end
          endcase
        end
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTL:    bus_rdata = {mode_q, first_q, last_q};
      A_STAT:   bus_rdata = {busy_q, int_q, inte_q, paus_q, src_q, 2'b00};
      A_RES_LO: bus_rdata = result_q[LO_W-1:0];
      default:  bus_rdata = {s10_q, {(REG_W-1-(RES_W-LO_W)){1'b0}}, result_q[RES_W-1:LO_W]};
    endcase
  end

  // R11
  int_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_done |=> int_q);

  // R12
  pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    paus_q |-> !core_busy);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !core_busy);

  // R7
  abort_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_ev |=> (!busy_q && !sample_en));
endmodule

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       ext_trig_n = 1'b1;
  logic       tmr_trig = 1'b0;
  logic       cmp_hi;
  logic [9:0] trial_code;
  logic       sample_en;
  logic [2:0] chan_sel;
  logic       irq;

  int an [8];
  int nchk = 0;
  int nfail = 0;
  logic [7:0] v;

  always #5 clk = ~clk;

  // Analog model: each channel is a fixed level compared with the DAC code.
  assign cmp_hi = (an[chan_sel] >= int'(trial_code));

  adc_seq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_trig_n(ext_trig_n),
    .tmr_trig(tmr_trig), .cmp_hi(cmp_hi), .trial_code(trial_code),
    .sample_en(sample_en), .chan_sel(chan_sel), .irq(irq));

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Expected register view of a channel level.
  function automatic int exp_lo(input int lvl, input bit full);
    return full ? (lvl & 255) : ((lvl >> 2) & 255);
  endfunction
  function automatic int exp_hi(input int lvl, input bit full);
    return full ? (128 | (lvl >> 8)) : 0;
  endfunction

  task automatic chk_result(input string tag, input int lvl, input bit full);
    rd(2'd2, v); chk({tag, " low byte"}, v, exp_lo(lvl, full));
    rd(2'd3, v); chk({tag, " high byte"}, v, exp_hi(lvl, full));
  endtask

  task automatic chk_stat(input string tag, input int bit_no, input int exp);
    rd(2'd1, v); chk(tag, v[bit_no], exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    an[0] = 300; an[1] = 400; an[2] = 1023; an[3] = 512;
    an[4] = 111; an[5] = 677; an[6] = 100;  an[7] = 200;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v); chk("R1 reset register", v, 0);
    end
    chk("R1 irq at reset", irq, 0);
    cyc(20);
    chk("R1 idle without trigger", sample_en, 0);

    // R2 / R3 single 10-bit on channel 5, software start
    wr(2'd3, 8'h80);
    wr(2'd0, 8'h2D);
    wr(2'd1, 8'h22);
    rd(2'd1, v); chk("R13 start bit reads 0", v[1], 0); chk("R13 bit0 reads 0", v[0], 0);
    chk("R2 busy after start", v[7], 1);
    chk("R2 channel", chan_sel, 5);
    cyc(59); chk("R2 sampling through cycle 60", sample_en, 1);
    cyc(1);  chk("R2 sampling ends after 60", sample_en, 0);
    cyc(37); chk_stat("R2 flag low at 97", 6, 0);
    cyc(1);  chk_stat("R2 flag high at 98", 6, 1);
    chk_stat("R5 busy cleared after single", 7, 0);
    chk("R11 irq with enable", irq, 1);
    chk_result("R3 10-bit", an[5], 1'b1);
    wr(2'd1, 8'h20);
    chk_stat("R11 flag cleared by 0", 6, 0);
    chk("R11 irq cleared", irq, 0);
    wr(2'd1, 8'h60);
    chk_stat("R11 writing 1 does not set", 6, 0);

    // R4 / R9 8-bit, external falling edge
    wr(2'd3, 8'h00);
    wr(2'd0, 8'h12);
    wr(2'd1, 8'h24);
    tmr_trig = 1'b1; cyc(3); tmr_trig = 1'b0; cyc(3);
    chk_stat("R9 timer disabled ignored", 7, 0);
    chk("R9 timer disabled no sampling", sample_en, 0);
    ext_trig_n = 1'b0;
    cyc(1);
    chk_stat("R9 external edge starts", 7, 1);
    cyc(97); chk_stat("R9 flag low at 97", 6, 0);
    cyc(1);  chk_stat("R9 flag high at 98", 6, 1);
    chk_result("R4 8-bit", an[2], 1'b0);
    ext_trig_n = 1'b1;
    wr(2'd1, 8'h24);

    // R9 timer rising edge, 8-bit
    an[2] = 341;
    wr(2'd1, 8'h28);
    ext_trig_n = 1'b0; cyc(3); ext_trig_n = 1'b1; cyc(3);
    chk_stat("R9 external disabled ignored", 7, 0);
    tmr_trig = 1'b1;
    cyc(1);
    cyc(97); chk_stat("R9 timer flag low at 97", 6, 0);
    cyc(1);  chk_stat("R9 timer flag high at 98", 6, 1);
    chk_result("R4 8-bit timer", an[2], 1'b0);
    tmr_trig = 1'b0;
    wr(2'd1, 8'h28);

    // R5 / R6 / R10 wrapped scan 6,7,0,1
    wr(2'd3, 8'h80);
    wr(2'd0, 8'h31);
    wr(2'd1, 8'h22);
    for (int k = 0; k < 4; k++) begin
      int ch;
      ch = (6 + k) % 8;
      cyc(k == 0 ? 98 : 97);
      chk_stat("R6 scan flag", 6, 1);
      chk_result("R6 scan result", an[ch], 1'b1);
      chk_stat("R5 busy during/after scan", 7, (k == 3) ? 0 : 1);
      // R10: the acknowledge at k=1 carries a start request while busy
      wr(2'd1, (k == 1) ? 8'h22 : 8'h20);
    end
    cyc(120);
    chk_stat("R10 no extra pass", 7, 0);
    chk("R10 no sampling after pass", sample_en, 0);

    // R12 pause and release, window 0..2
    an[2] = 900;
    wr(2'd0, 8'h02);
    wr(2'd1, 8'h22);
    cyc(98);  chk_stat("R12 first flag", 6, 1);
    cyc(98);  chk_stat("R12 pause set", 4, 1);
    chk_result("R12 second result", an[1], 1'b1);
    cyc(20);
    chk("R12 held no sampling", sample_en, 0);
    chk_stat("R12 still busy", 7, 1);
    wr(2'd1, 8'h20);
    chk_stat("R12 pause released", 4, 0);
    cyc(97); chk_stat("R12 flag low before 98", 6, 0);
    cyc(1);  chk_stat("R12 flag after release", 6, 1);
    chk_result("R12 third result", an[2], 1'b1);
    chk_stat("R12 pass done", 7, 0);
    wr(2'd1, 8'h20);

    // R7 loop mode on channel 3, then abort
    wr(2'd0, 8'h9B);
    wr(2'd1, 8'h22);
    cyc(98); chk_stat("R7 first loop result", 6, 1);
    wr(2'd1, 8'hA0);
    cyc(97); chk_stat("R7 second loop flag", 6, 1);
    chk_result("R7 loop result", an[3], 1'b1);
    chk_stat("R7 busy while looping", 7, 1);
    wr(2'd1, 8'h20);
    chk_stat("R7 aborted", 7, 0);
    chk("R7 sampling stopped", sample_en, 0);
    cyc(100);
    chk_stat("R7 no further result", 6, 0);

    // R8 stepped mode, window 4..5
    wr(2'd0, 8'hE5);
    wr(2'd1, 8'h22);
    cyc(98); chk_stat("R8 first step flag", 6, 1);
    chk_result("R8 first step", an[4], 1'b1);
    cyc(50);
    chk("R8 waiting no sampling", sample_en, 0);
    chk_stat("R8 busy while waiting", 7, 1);
    wr(2'd1, 8'hA0);
    wr(2'd1, 8'hA2);
    cyc(97); chk_stat("R8 second flag low at 97", 6, 0);
    cyc(1);  chk_stat("R8 second flag", 6, 1);
    chk_result("R8 second step", an[5], 1'b1);
    wr(2'd1, 8'hA0);
    wr(2'd1, 8'hA2);
    cyc(98);
    chk_result("R8 wraps to first", an[4], 1'b1);
    wr(2'd1, 8'h20);
    chk_stat("R8 abort in stepped mode", 7, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule